// File: doc/BRIEF.md
# Parallel Flash Command Sequence Decoder

This block is the device-side command interpreter of a byte-wide parallel flash model. It receives already-latched bus write cycles, each an address plus a data byte, and follows the multi-cycle unlock handshakes that guard every state-changing command. When a handshake completes, it pulses a start strobe to an internal operation engine. The strobe carries an operation kind, a target address and a data byte. A busy flag stays high for a parameterised number of clock cycles, which model the program or erase time.

A three-cycle handshake puts the decoder into identification mode. In that mode, reads at the two lowest addresses return fixed manufacturer and device bytes in place of array data. Any write cycle that breaks a handshake drops the decoder back to plain read mode. Every write that arrives while an operation runs is dropped without effect.

Top module: `flash_cmd_decoder`

## Requirements
- R1: A synchronous active-high reset clears `busy`, `op_start` and `id_mode`, and returns the handshake tracker to its first step.
- R2: The writes AA@5555, 55@2AAA, A0@5555 followed by any write (A, D) pulse `op_start` in the clock cycle after that fourth write. In that cycle `op_kind` is 0 (program), `op_addr` is A and `op_data` is D.
- R3: The writes AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA followed by data 0x30 at any address A start a sector erase. The outputs are `op_kind` 1, `op_addr` equal to A with its low SECT_W bits cleared, and `op_data` 0xFF (the erased fill value).
- R4: The same five-cycle prefix followed by 0x10 at 5555 starts a chip erase. The outputs are `op_kind` 2, `op_addr` 0 and `op_data` 0xFF.
- R5: Command address matching uses only address bits 14..0. Bit 15 and above may take any value during handshake cycles.
- R6: AA@5555, 55@2AAA, 90@5555 sets `id_mode`. While `id_mode` is set, `id_data` returns 0xBF for `rd_addr` 0, DEV_ID (default 0xB4) for `rd_addr` 1, and 0x00 for any other address. When `id_mode` is clear, `id_data` is 0x00.
- R7: `id_mode` is cleared by the single write F0 at any address, and also by the three-cycle exit AA@5555, 55@2AAA, F0@5555.
- R8: A write that does not match the expected next step of a handshake returns the tracker to its first step and clears `id_mode`. The write starts nothing, so a later continuation of the broken handshake starts nothing either.
- R9: `busy` rises in the same cycle as `op_start` and stays high for exactly PROG_CYC, SECT_CYC or CHIP_CYC cycles, chosen by the kind of the operation.
- R10: A write that arrives while `busy` is high is ignored. It does not advance or break a handshake, it leaves `id_mode` unchanged, and it starts nothing.
- R11: `op_start` lasts exactly one cycle per completed handshake and is never high while `busy` was already high in the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | A latched write cycle is presented this clock |
| wr_addr | input | ADDR_W | Latched write address |
| wr_data | input | 8 | Latched write data |
| rd_addr | input | ADDR_W | Current read address |
| op_start | output | 1 | One-cycle start strobe to the operation engine |
| op_kind | output | 2 | 0 program, 1 sector erase, 2 chip erase |
| op_addr | output | ADDR_W | Target byte address or sector base |
| op_data | output | 8 | Program byte, or 0xFF for erase |
| busy | output | 1 | Operation in progress |
| id_mode | output | 1 | Identification reads selected |
| id_data | output | 8 | Identifier byte for rd_addr |

## Verification
Each handshake runs in its plain form and again with address bit 15 set. This separates a full-width address compare from the 15-bit compare. Broken handshakes put a wrong byte at the second, third and final steps, and they also break a sequence while in identification mode. These show whether the tracker restarts or wrongly resumes. Handshakes and identification entry sent during a chip erase test the lockout: a partial unlock given while busy must not be completed by writes sent after busy falls. A per-clock reference model compares every output, including the exact length of each busy window.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam int CMD_W = 15;

    typedef enum logic [1:0] {
        OPK_PROG = 2'd0,
        OPK_SECT = 2'd1,
        OPK_CHIP = 2'd2
    } op_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_UNL1,
        ST_UNL2,
        ST_PROG,
        ST_ERS1,
        ST_ERS2,
        ST_ERS3
    } seq_state_e;

    localparam logic [CMD_W-1:0] CMD_ADDR_A = 15'h5555;
    localparam logic [CMD_W-1:0] CMD_ADDR_B = 15'h2AAA;

    localparam logic [7:0] CODE_KEY1    = 8'hAA;
    localparam logic [7:0] CODE_KEY2    = 8'h55;
    localparam logic [7:0] CODE_PROG    = 8'hA0;
    localparam logic [7:0] CODE_ERASE   = 8'h80;
    localparam logic [7:0] CODE_SECT    = 8'h30;
    localparam logic [7:0] CODE_CHIP    = 8'h10;
    localparam logic [7:0] CODE_ID_IN   = 8'h90;
    localparam logic [7:0] CODE_ID_OUT  = 8'hF0;
    localparam logic [7:0] ERASED_BYTE  = 8'hFF;

    // Start request handed from the tracker to the operation timer.
    typedef struct packed {
        logic     valid;
        op_kind_e kind;
        logic [7:0] data;
    } op_req_t;

    function automatic logic bus_hit(
        input logic [CMD_W-1:0] a,
        input logic [7:0]       d,
        input logic [CMD_W-1:0] ea,
        input logic [7:0]       ed
    );
        return (a == ea) && (d == ed);
    endfunction

    function automatic int op_cycles(
        input op_kind_e k,
        input int       prog_c,
        input int       sect_c,
        input int       chip_c
    );
        case (k)
            OPK_PROG: return prog_c;
            OPK_SECT: return sect_c;
            default:  return chip_c;
        endcase
    endfunction

endpackage

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int SECT_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              busy,
    output op_req_t           req,
    output logic              op_start,
    output op_kind_e          op_kind,
    output logic [ADDR_W-1:0] op_addr,
    output logic [7:0]        op_data,
    output logic              id_mode
);

    localparam logic [ADDR_W-1:0] OFFS_MASK = (ADDR_W)'((1 << SECT_W) - 1);

    seq_state_e        state_q, state_d;
    logic              id_d;
    logic              take;
    logic [CMD_W-1:0]  a15;
    logic [ADDR_W-1:0] req_addr;

    assign take = wr_valid && !busy;
    assign a15  = wr_addr[CMD_W-1:0];

    always_comb begin
        state_d   = state_q;
        id_d      = id_mode;
        req       = '0;
        req.kind  = OPK_PROG;
        req.data  = wr_data;
        req_addr  = wr_addr;
        if (take) begin
            // Default outcome of any step: abort to read mode.
            state_d = ST_IDLE;
            id_d    = 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (bus_hit(a15, wr_data, CMD_ADDR_A, CODE_KEY1)) begin
                        state_d = ST_UNL1;
                        id_d    = id_mode;
                    end
                end
                ST_UNL1: begin
                    if (bus_hit(a15, wr_data, CMD_ADDR_B, CODE_KEY2)) begin
                        state_d = ST_UNL2;
                        id_d    = id_mode;
                    end
                end
                ST_UNL2: begin
                    if (a15 == CMD_ADDR_A) begin
                        case (wr_data)
                            CODE_PROG:  begin state_d = ST_PROG; id_d = id_mode; end
                            CODE_ERASE: begin state_d = ST_ERS1; id_d = id_mode; end
                            CODE_ID_IN: id_d = 1'b1;
                            default:    id_d = 1'b0;
                        endcase
                    end
                end
                ST_PROG: begin
                    req.valid = 1'b1;
                    req.kind  = OPK_PROG;
                end
                ST_ERS1: begin
                    if (bus_hit(a15, wr_data, CMD_ADDR_A, CODE_KEY1)) begin
                        state_d = ST_ERS2;
                        id_d    = id_mode;
                    end
                end
                ST_ERS2: begin
                    if (bus_hit(a15, wr_data, CMD_ADDR_B, CODE_KEY2)) begin
                        state_d = ST_ERS3;
                        id_d    = id_mode;
                    end
                end
                ST_ERS3: begin
                    if (wr_data == CODE_SECT) begin
                        req.valid = 1'b1;
                        req.kind  = OPK_SECT;
                        req.data  = ERASED_BYTE;
                        req_addr  = wr_addr & ~OFFS_MASK;
                    end else if (bus_hit(a15, wr_data, CMD_ADDR_A, CODE_CHIP)) begin
                        req.valid = 1'b1;
                        req.kind  = OPK_CHIP;
                        req.data  = ERASED_BYTE;
                        req_addr  = '0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            id_mode  <= 1'b0;
            op_start <= 1'b0;
            op_kind  <= OPK_PROG;
            op_addr  <= '0;
            op_data  <= '0;
        end else begin
            state_q  <= state_d;
            id_mode  <= id_d;
            op_start <= req.valid;
            if (req.valid) begin
                op_kind <= req.kind;
                op_addr <= req_addr;
                op_data <= req.data;
            end
        end
    end

endmodule

// File: rtl/flash_op_timer.sv
module flash_op_timer
    import flash_cmd_pkg::*;
#(
    parameter int PROG_CYC = 8,
    parameter int SECT_CYC = 20,
    parameter int CHIP_CYC = 40
) (
    input  logic     clk,
    input  logic     rst,
    input  op_req_t  req,
    output logic     busy
);

    localparam int MAX_CYC = (PROG_CYC > SECT_CYC) ?
                             ((PROG_CYC > CHIP_CYC) ? PROG_CYC : CHIP_CYC) :
                             ((SECT_CYC > CHIP_CYC) ? SECT_CYC : CHIP_CYC);
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic [CNT_W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            left_q <= '0;
        end else if (req.valid) begin
            busy   <= 1'b1;
            left_q <= CNT_W'(op_cycles(req.kind, PROG_CYC, SECT_CYC, CHIP_CYC) - 1);
        end else if (busy) begin
            if (left_q == '0) begin
                busy <= 1'b0;
            end else begin
                left_q <= left_q - 1'b1;
            end
        end
    end

endmodule

// File: rtl/flash_id_rom.sv
module flash_id_rom #(
    parameter int         ADDR_W = 16,
    parameter logic [7:0] MFR_ID = 8'hBF,
    parameter logic [7:0] DEV_ID = 8'hB4
) (
    input  logic              id_mode,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        id_data
);

    localparam int NUM_IDS = 2;

    logic [7:0] id_table [NUM_IDS];

    generate
        for (genvar i = 0; i < NUM_IDS; i++) begin : g_id
            assign id_table[i] = (i == 0) ? MFR_ID : DEV_ID;
        end
    endgenerate

    always_comb begin
        id_data = 8'h00;
        if (id_mode && (rd_addr[ADDR_W-1:1] == '0)) begin
            id_data = id_table[rd_addr[0]];
        end
    end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int         ADDR_W   = 16,
    parameter int         SECT_W   = 12,
    parameter int         PROG_CYC = 8,
    parameter int         SECT_CYC = 20,
    parameter int         CHIP_CYC = 40,
    parameter logic [7:0] MFR_ID   = 8'hBF,
    parameter logic [7:0] DEV_ID   = 8'hB4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              op_start,
    output logic [1:0]        op_kind,
    output logic [ADDR_W-1:0] op_addr,
    output logic [7:0]        op_data,
    output logic              busy,
    output logic              id_mode,
    output logic [7:0]        id_data
);

    op_req_t  req;
    op_kind_e kind_q;

    flash_cmd_seq #(
        .ADDR_W (ADDR_W),
        .SECT_W (SECT_W)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .busy     (busy),
        .req      (req),
        .op_start (op_start),
        .op_kind  (kind_q),
        .op_addr  (op_addr),
        .op_data  (op_data),
        .id_mode  (id_mode)
    );

    flash_op_timer #(
        .PROG_CYC (PROG_CYC),
        .SECT_CYC (SECT_CYC),
        .CHIP_CYC (CHIP_CYC)
    ) u_timer (
        .clk  (clk),
        .rst  (rst),
        .req  (req),
        .busy (busy)
    );

    flash_id_rom #(
        .ADDR_W (ADDR_W),
        .MFR_ID (MFR_ID),
        .DEV_ID (DEV_ID)
    ) u_idrom (
        .id_mode (id_mode),
        .rd_addr (rd_addr),
        .id_data (id_data)
    );

    assign op_kind = kind_q;

endmodule

// File: rtl/flash_cmd_checker.sv
module flash_cmd_checker #(
    parameter int ADDR_W   = 16,
    parameter int SECT_W   = 12,
    parameter int PROG_CYC = 8,
    parameter int SECT_CYC = 20,
    parameter int CHIP_CYC = 40
) (
    input logic              clk,
    input logic              rst,
    input logic              op_start,
    input logic [1:0]        op_kind,
    input logic [ADDR_W-1:0] op_addr,
    input logic              busy,
    input logic              id_mode
);

    logic       started = 1'b0;
    int         run_len;
    logic [1:0] run_kind;
    int         want_len;

    always_ff @(posedge clk) begin
        started <= 1'b1;
        if (rst) begin
            run_len  <= 0;
            run_kind <= 2'd0;
        end else if (op_start) begin
            run_len  <= 1;
            run_kind <= op_kind;
        end else if (busy) begin
            run_len <= run_len + 1;
        end
    end

    always_comb begin
        case (run_kind)
            2'd0:    want_len = PROG_CYC;
            2'd1:    want_len = SECT_CYC;
            default: want_len = CHIP_CYC;
        endcase
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        started && $past(rst) |-> !busy && !op_start && !id_mode);

    assert_start_sets_busy_R9: assert property (@(posedge clk) disable iff (rst)
        op_start |-> busy);

    assert_busy_window_R9: assert property (@(posedge clk) disable iff (rst)
        started && $fell(busy) |-> run_len == want_len);

    assert_start_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        op_start |=> !op_start);

    assert_no_start_when_busy_R10: assert property (@(posedge clk) disable iff (rst)
        busy |=> !op_start);

    assert_id_frozen_busy_R10: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(id_mode));

    assert_sector_aligned_R3: assert property (@(posedge clk) disable iff (rst)
        op_start && op_kind == 2'd1 |-> op_addr[SECT_W-1:0] == '0);

    assert_chip_addr_zero_R4: assert property (@(posedge clk) disable iff (rst)
        op_start && op_kind == 2'd2 |-> op_addr == '0);

endmodule

bind flash_cmd_decoder flash_cmd_checker #(
    .ADDR_W   (ADDR_W),
    .SECT_W   (SECT_W),
    .PROG_CYC (PROG_CYC),
    .SECT_CYC (SECT_CYC),
    .CHIP_CYC (CHIP_CYC)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .op_start (op_start),
    .op_kind  (op_kind),
    .op_addr  (op_addr),
    .busy     (busy),
    .id_mode  (id_mode)
);

// File: tb/flash_cmd_decoder_bench.sv
module flash_cmd_decoder_bench;

    localparam int PROG_C = 8;
    localparam int SECT_C = 20;
    localparam int CHIP_C = 40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_valid = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [15:0] rd_addr = '0;
    logic        op_start;
    logic [1:0]  op_kind;
    logic [15:0] op_addr;
    logic [7:0]  op_data;
    logic        busy;
    logic        id_mode;
    logic [7:0]  id_data;

    int    checks = 0;
    int    failures = 0;
    string cur_req = "R1";
    logic  done = 1'b0;

    always #10 clk = ~clk;

    flash_cmd_decoder #(
        .ADDR_W (16), .SECT_W (12),
        .PROG_CYC (PROG_C), .SECT_CYC (SECT_C), .CHIP_CYC (CHIP_C),
        .MFR_ID (8'hBF), .DEV_ID (8'hB4)
    ) u_flash_cmd_decoder (
        .clk (clk), .rst (rst), .wr_valid (wr_valid), .wr_addr (wr_addr),
        .wr_data (wr_data), .rd_addr (rd_addr), .op_start (op_start),
        .op_kind (op_kind), .op_addr (op_addr), .op_data (op_data),
        .busy (busy), .id_mode (id_mode), .id_data (id_data)
    );

    // ---------------- reference model ----------------
    logic        m_busy, m_start, m_id;
    int          m_rem, m_step;
    logic [1:0]  m_kind;
    logic [15:0] m_addr;
    logic [7:0]  m_data;

    task automatic launch(input logic [1:0] k, input logic [15:0] a,
                          input logic [7:0] d, input int dur);
        m_start = 1'b1; m_busy = 1'b1; m_rem = dur;
        m_kind = k; m_addr = a; m_data = d;
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_start = 0; m_id = 0; m_rem = 0; m_step = 0;
            m_kind = 0; m_addr = 0; m_data = 0;
        end else begin
            logic        was_busy;
            logic [15:0] a;
            logic [7:0]  d;
            was_busy = m_busy;
            a = wr_addr & 16'h7FFF;
            d = wr_data;
            m_start = 0;
            if (m_busy) begin
                m_rem--;
                if (m_rem == 0) m_busy = 0;
            end
            if (wr_valid && !was_busy) begin
                case (m_step)
                    0: if (a == 16'h5555 && d == 8'hAA) m_step = 1; else m_id = 0;
                    1: if (a == 16'h2AAA && d == 8'h55) m_step = 2;
                       else begin m_step = 0; m_id = 0; end
                    2: begin
                        m_step = 0;
                        if (a == 16'h5555 && d == 8'hA0) m_step = 3;
                        else if (a == 16'h5555 && d == 8'h80) m_step = 4;
                        else if (a == 16'h5555 && d == 8'h90) m_id = 1;
                        else m_id = 0;
                    end
                    3: begin m_step = 0; m_id = 0; launch(2'd0, wr_addr, d, PROG_C); end
                    4: if (a == 16'h5555 && d == 8'hAA) m_step = 5;
                       else begin m_step = 0; m_id = 0; end
                    5: if (a == 16'h2AAA && d == 8'h55) m_step = 6;
                       else begin m_step = 0; m_id = 0; end
                    default: begin
                        m_step = 0; m_id = 0;
                        if (d == 8'h30) launch(2'd1, wr_addr & 16'hF000, 8'hFF, SECT_C);
                        else if (a == 16'h5555 && d == 8'h10) launch(2'd2, 16'h0, 8'hFF, CHIP_C);
                    end
                endcase
            end
        end
    end

    task automatic chk(input logic ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- per-clock comparison and monitors ----------------
    int          n_prog = 0, n_sect = 0, n_chip = 0;
    int          busy_run = 0, last_run = 0;
    logic [15:0] last_addr = '0;
    logic        prev_start = 1'b0, dbl_start = 1'b0;

    always @(negedge clk) begin
        if (!rst && !done) begin
            logic [7:0] exp_id;
            exp_id = !m_id ? 8'h00 : (rd_addr == 16'd0) ? 8'hBF :
                     (rd_addr == 16'd1) ? 8'hB4 : 8'h00;
            chk(busy === m_busy, cur_req, "busy", busy, m_busy);
            chk(op_start === m_start, cur_req, "op_start", op_start, m_start);
            chk(id_mode === m_id, cur_req, "id_mode", id_mode, m_id);
            chk(id_data === exp_id, cur_req, "id_data", id_data, exp_id);
            if (m_start) begin
                chk(op_kind === m_kind, cur_req, "op_kind", op_kind, m_kind);
                chk(op_addr === m_addr, cur_req, "op_addr", op_addr, m_addr);
                chk(op_data === m_data, cur_req, "op_data", op_data, m_data);
            end
            if (op_start) begin
                last_addr = op_addr;
                case (op_kind)
                    2'd0: n_prog++;
                    2'd1: n_sect++;
                    default: n_chip++;
                endcase
            end
            if (op_start && prev_start) dbl_start = 1'b1;
            prev_start = op_start;
            if (busy) busy_run++;
            else if (busy_run != 0) begin last_run = busy_run; busy_run = 0; end
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        wr_addr = a; wr_data = d; wr_valid = 1'b1;
        @(posedge clk); #2;
        wr_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic unlock(input logic [15:0] hi);
        wr(16'h5555 | hi, 8'hAA);
        wr(16'h2AAA | hi, 8'h55);
    endtask

    task automatic erase_prefix;
        unlock(16'h0); wr(16'h5555, 8'h80); unlock(16'h0);
    endtask

    initial begin
        int snap;
        idle(3);
        rst = 1'b0;
        #1;
        cur_req = "R1";
        chk(!busy && !op_start && !id_mode, "R1", "reset outputs",
            {busy, op_start, id_mode}, 0);
        idle(2);

        cur_req = "R2";
        unlock(16'h0); wr(16'h5555, 8'hA0); wr(16'h1234, 8'h5A);
        idle(PROG_C + 3);
        chk(n_prog == 1, "R2", "program starts", n_prog, 1);
        chk(last_run == PROG_C, "R9", "program busy length", last_run, PROG_C);

        cur_req = "R5";
        unlock(16'h8000); wr(16'hD555, 8'hA0); wr(16'hFFFE, 8'h3C);
        idle(PROG_C + 3);
        chk(n_prog == 2, "R5", "high bits ignored", n_prog, 2);

        cur_req = "R3";
        erase_prefix(); wr(16'h3ABC, 8'h30);
        idle(SECT_C + 3);
        chk(n_sect == 1 && last_addr == 16'h3000, "R3", "sector base",
            last_addr, 16'h3000);
        chk(last_run == SECT_C, "R9", "sector busy length", last_run, SECT_C);

        cur_req = "R4";
        erase_prefix(); wr(16'h5555, 8'h10);
        idle(CHIP_C + 3);
        chk(n_chip == 1, "R4", "chip erase starts", n_chip, 1);
        chk(last_run == CHIP_C, "R9", "chip busy length", last_run, CHIP_C);

        cur_req = "R6";
        unlock(16'h0); wr(16'h5555, 8'h90);
        rd_addr = 16'd0; idle(1);
        chk(id_data == 8'hBF, "R6", "manufacturer byte", id_data, 8'hBF);
        rd_addr = 16'd1; idle(1);
        chk(id_data == 8'hB4, "R6", "device byte", id_data, 8'hB4);
        rd_addr = 16'd2; idle(1);
        rd_addr = 16'd0;

        cur_req = "R7";
        wr(16'h7777, 8'hF0); idle(1);
        chk(!id_mode, "R7", "single-cycle exit", id_mode, 0);
        unlock(16'h0); wr(16'h5555, 8'h90); idle(1);
        unlock(16'h0); idle(1);
        chk(id_mode, "R7", "id kept during partial unlock", id_mode, 1);
        wr(16'h5555, 8'hF0); idle(1);
        chk(!id_mode, "R7", "three-cycle exit", id_mode, 0);

        cur_req = "R8";
        snap = n_prog + n_sect + n_chip;
        unlock(16'h0); wr(16'h5555, 8'hA5); wr(16'h0100, 8'h11);
        wr(16'h5555, 8'hAA); wr(16'h2AAB, 8'h55); wr(16'h5555, 8'hA0); wr(16'h0200, 8'h22);
        erase_prefix(); wr(16'h5554, 8'h10);
        unlock(16'h0); wr(16'h5555, 8'h90); wr(16'h0000, 8'h12);
        idle(2);
        chk(!id_mode, "R8", "id cleared by bad cycle", id_mode, 0);
        chk(n_prog + n_sect + n_chip == snap, "R8", "no start after abort",
            n_prog + n_sect + n_chip, snap);

        cur_req = "R10";
        erase_prefix(); wr(16'h5555, 8'h10);
        unlock(16'h0); wr(16'h5555, 8'h90);
        idle(2);
        chk(!id_mode, "R10", "id entry ignored while busy", id_mode, 0);
        unlock(16'h0);
        idle(CHIP_C);
        snap = n_prog;
        wr(16'h5555, 8'hA0); wr(16'h0300, 8'h33);
        idle(PROG_C + 3);
        chk(n_prog == snap, "R10", "busy-time unlock not kept", n_prog, snap);

        cur_req = "R11";
        chk(!dbl_start, "R11", "start is a single pulse", dbl_start, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired in %s actual=running expected=finished", cur_req);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule